// File: doc/BRIEF.md
# GPIO interrupt detect and aggregator

This block watches up to 95 general-purpose pins and turns qualifying activity on each into a sticky pending flag. Every pin carries two configuration bits: a trigger-class bit that picks edge or level sensing, and a polarity bit that flips which direction or level counts. Together they give four trigger kinds: rising edge, falling edge, level low and level high. Only a pin that is configured for general-purpose use and as an input may raise its flag; any other pin holds its flag at zero.

Flags are grouped into 32-bit words and read out as one flat vector. A host clears flags by writing ones to a word through a clear strobe. A separate per-pin enable bitmap, loaded one word at a time, decides which flags reach the single combined interrupt line. A flag still latches while its pin is disabled, so the event is not lost and appears on the line once the pin is enabled.

Pin levels arrive asynchronously and pass through a synchronizer before detection. Edge sensing compares the synchronized level with the sample taken one clock earlier.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset every status bit, every enable bit and `irq_out` are 0, and the synchronizer and previous-sample registers hold 0.
- R2: With trigger-class 0 and polarity 0 (rising edge), a 0-to-1 change of a pin's level sets its status bit; a level change driven before clock edge k shows in `sts_words` after edge k+2 and not before.
- R3: With trigger-class 0 and polarity 1 (falling edge), a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R4: With trigger-class 1 and polarity 0 (level low), the status bit is set on every clock on which the synchronized level is 0, so a clear sticks only once the level is 1.
- R5: With trigger-class 1 and polarity 1 (level high), the status bit is set on every clock on which the synchronized level is 1, so a clear sticks only once the level is 0.
- R6: A clear strobe with word index w clears status bit 32*w+b for every b where data bit b is 1; data bits that are 0 leave their bits unchanged, and an index of 3 or above changes nothing.
- R7: When a trigger event and a clear reach the same status bit on the same clock, the bit ends up 1.
- R8: An enable strobe with word index w loads enable bits 32*w to 32*w+31 from its data; `irq_out` is 1 exactly when some pin has both status and enable set, and status bits latch regardless of the enable.
- R9: A pin whose general-purpose-use bit or input-direction bit is 0 has status 0 after the next clock edge, and no level or edge on it sets its status.
- R10: Bit 95 of `sts_words`, which pads the last word, always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 95 | Asynchronous pin levels |
| cfg_gpio_use | input | 95 | 1: pin is in general-purpose use |
| cfg_dir_in | input | 95 | 1: pin is an input |
| cfg_trig_level | input | 95 | Trigger class, 0 edge, 1 level |
| cfg_trig_inv | input | 95 | Polarity: falling/high when 1, rising/low when 0 |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_idx | input | 2 | Word index of the clear |
| sts_clr_data | input | 32 | Ones mark status bits to clear |
| ena_we | input | 1 | Enable word write strobe |
| ena_idx | input | 2 | Word index of the enable write |
| ena_data | input | 32 | New enable bits for that word |
| sts_words | output | 96 | Status words, word w at bits 32*w+31 to 32*w |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench aims at the two-clock synchronizer latency, so a design that sampled the raw pin or skipped the previous-sample register would flag a pin one clock early. It times a clear onto the very clock on which a rising edge lands; a design giving the clear priority would lose that event. Clearing a level-sensitive pin while its level is still active must leave the flag set, which catches a design that treats level modes as edges. It also drops the input-direction bit on a pin with a pending flag and writes an out-of-range word index, where a design that kept the stale flag or aliased word 3 onto word 0 or 2 would show a wrong status bit.

// File: rtl/girq_pkg.sv
`timescale 1ns/1ps
package girq_pkg;

    // Trigger kinds, encoded as {trigger class, polarity}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_kind_e;

    function automatic trig_kind_e decode_trig(input logic lvl_sel, input logic inv);
        return trig_kind_e'({lvl_sel, inv});
    endfunction

endpackage

// File: rtl/girq_sync.sv
`timescale 1ns/1ps
module girq_sync #(
    parameter int WIDTH  = 95,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl_now,
    output logic [WIDTH-1:0] lvl_prev
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl_now  = stage_q[STAGES-1];
    assign lvl_prev = prev_q;

endmodule

// File: rtl/girq_trig_detect.sv
`timescale 1ns/1ps
module girq_trig_detect
    import girq_pkg::*;
#(
    parameter int NUM_PINS = 95
) (
    input  logic [NUM_PINS-1:0] lvl_now,
    input  logic [NUM_PINS-1:0] lvl_prev,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_inv,
    output logic [NUM_PINS-1:0] hit
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        trig_kind_e kind;
        assign kind = decode_trig(trig_level[i], trig_inv[i]);

        always_comb begin
            unique case (kind)
                TRIG_RISE: hit[i] =  lvl_now[i] & ~lvl_prev[i];
                TRIG_FALL: hit[i] = ~lvl_now[i] &  lvl_prev[i];
                TRIG_LOW:  hit[i] = ~lvl_now[i];
                TRIG_HIGH: hit[i] =  lvl_now[i];
                default:   hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/girq_status_bank.sv
`timescale 1ns/1ps
module girq_status_bank #(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] hit,
    input  logic [NUM_PINS-1:0] gpio_use,
    input  logic [NUM_PINS-1:0] dir_in,
    input  logic                clr_we,
    input  logic [IDX_W-1:0]    clr_idx,
    input  logic [WORD_W-1:0]   clr_data,
    output logic [NUM_PINS-1:0] sts
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        localparam int WORD = i / WORD_W;
        localparam int BIT  = i % WORD_W;

        logic qual;
        logic clr;

        assign qual = gpio_use[i] & dir_in[i];
        assign clr  = clr_we && (clr_idx == IDX_W'(WORD)) && clr_data[BIT];

        // Priority: disqualified pin -> 0, trigger event -> 1, clear -> 0
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts[i] <= 1'b0;
            end else if (!qual) begin
                sts[i] <= 1'b0;
            end else if (hit[i]) begin
                sts[i] <= 1'b1;
            end else if (clr) begin
                sts[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/girq_mask_reduce.sv
`timescale 1ns/1ps
module girq_mask_reduce #(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ena_we,
    input  logic [IDX_W-1:0]    ena_idx,
    input  logic [WORD_W-1:0]   ena_data,
    input  logic [NUM_PINS-1:0] sts,
    output logic                irq
);

    logic [NUM_PINS-1:0] ena_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ena
        localparam int WORD = i / WORD_W;
        localparam int BIT  = i % WORD_W;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ena_q[i] <= 1'b0;
            end else if (ena_we && (ena_idx == IDX_W'(WORD))) begin
                ena_q[i] <= ena_data[BIT];
            end
        end
    end

    assign irq = |(sts & ena_q);

endmodule

// File: rtl/gpio_irq_agg.sv
`timescale 1ns/1ps
module gpio_irq_agg #(
    parameter int NUM_PINS    = 95,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_WORDS  = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1,
    localparam int PAD_W      = NUM_WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] cfg_gpio_use,
    input  logic [NUM_PINS-1:0] cfg_dir_in,
    input  logic [NUM_PINS-1:0] cfg_trig_level,
    input  logic [NUM_PINS-1:0] cfg_trig_inv,
    input  logic                sts_clr_we,
    input  logic [IDX_W-1:0]    sts_clr_idx,
    input  logic [WORD_W-1:0]   sts_clr_data,
    input  logic                ena_we,
    input  logic [IDX_W-1:0]    ena_idx,
    input  logic [WORD_W-1:0]   ena_data,
    output logic [PAD_W-1:0]    sts_words,
    output logic                irq_out
);

    logic [NUM_PINS-1:0] lvl_now;
    logic [NUM_PINS-1:0] lvl_prev;
    logic [NUM_PINS-1:0] trig_hit;
    logic [NUM_PINS-1:0] sts_vec;

    girq_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_level),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    girq_trig_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .lvl_now    (lvl_now),
        .lvl_prev   (lvl_prev),
        .trig_level (cfg_trig_level),
        .trig_inv   (cfg_trig_inv),
        .hit        (trig_hit)
    );

    girq_status_bank #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (trig_hit),
        .gpio_use (cfg_gpio_use),
        .dir_in   (cfg_dir_in),
        .clr_we   (sts_clr_we),
        .clr_idx  (sts_clr_idx),
        .clr_data (sts_clr_data),
        .sts      (sts_vec)
    );

    girq_mask_reduce #(
        .NUM_PINS (NUM_PINS),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W)
    ) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .ena_we   (ena_we),
        .ena_idx  (ena_idx),
        .ena_data (ena_data),
        .sts      (sts_vec),
        .irq      (irq_out)
    );

    if (PAD_W > NUM_PINS) begin : g_pad
        assign sts_words = {{(PAD_W - NUM_PINS){1'b0}}, sts_vec};
    end else begin : g_nopad
        assign sts_words = sts_vec;
    end

endmodule

// File: rtl/girq_checker.sv
`timescale 1ns/1ps
module girq_checker #(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] cfg_gpio_use,
    input logic [NUM_PINS-1:0] cfg_dir_in,
    input logic                sts_clr_we,
    input logic [IDX_W-1:0]    sts_clr_idx,
    input logic [WORD_W-1:0]   sts_clr_data,
    input logic [NUM_PINS-1:0] sts_vec,
    input logic [NUM_PINS-1:0] trig_hit,
    input logic                irq_out
);

    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] qual;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            clr_mask[i] = sts_clr_we && (int'(sts_clr_idx) == i / WORD_W)
                          && sts_clr_data[i % WORD_W];
        end
    end

    assign qual = cfg_gpio_use & cfg_dir_in;

    // R2: a status bit rises only after a trigger event
    p_set_by_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vec & ~$past(sts_vec) & ~$past(trig_hit)) == '0);

    // R6: a cleared bit with no event drops
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_mask & ~trig_hit) & sts_vec) == '0));

    // R7: an event on a qualified pin always leaves the bit set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig_hit & qual) & ~sts_vec) == '0));

    // R8: the line rises only with some status pending
    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|sts_vec));

    // R9: a disqualified pin has no status after the next edge
    p_unqualified_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_vec & ~$past(qual)) == '0));

endmodule

bind gpio_irq_agg girq_checker #(
    .NUM_PINS (NUM_PINS),
    .WORD_W   (WORD_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_gpio_use (cfg_gpio_use),
    .cfg_dir_in   (cfg_dir_in),
    .sts_clr_we   (sts_clr_we),
    .sts_clr_idx  (sts_clr_idx),
    .sts_clr_data (sts_clr_data),
    .sts_vec      (sts_vec),
    .trig_hit     (trig_hit),
    .irq_out      (irq_out)
);

// File: tb/sim_gpio_irq_agg.sv
`timescale 1ns/1ps
module sim_gpio_irq_agg;

    localparam int NP = 95;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_level = '0;
    logic [NP-1:0] cfg_gpio_use = '1;
    logic [NP-1:0] cfg_dir_in = '1;
    logic [NP-1:0] cfg_trig_level = '0;
    logic [NP-1:0] cfg_trig_inv = '0;
    logic          sts_clr_we = 1'b0;
    logic [1:0]    sts_clr_idx = '0;
    logic [31:0]   sts_clr_data = '0;
    logic          ena_we = 1'b0;
    logic [1:0]    ena_idx = '0;
    logic [31:0]   ena_data = '0;
    logic [95:0]   sts_words;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_agg u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_level      (pin_level),
        .cfg_gpio_use   (cfg_gpio_use),
        .cfg_dir_in     (cfg_dir_in),
        .cfg_trig_level (cfg_trig_level),
        .cfg_trig_inv   (cfg_trig_inv),
        .sts_clr_we     (sts_clr_we),
        .sts_clr_idx    (sts_clr_idx),
        .sts_clr_data   (sts_clr_data),
        .ena_we         (ena_we),
        .ena_idx        (ena_idx),
        .ena_data       (ena_data),
        .sts_words      (sts_words),
        .irq_out        (irq_out)
    );

    // Behavioural reference: two sync samples, one old sample, flags, enables
    bit [NP-1:0] m_s1, m_s2, m_old, m_sts, m_ena;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_old = '0; m_sts = '0; m_ena = '0;
        end else begin
            bit [NP-1:0] nxt;
            for (int i = 0; i < NP; i++) begin
                bit ev, wipe;
                if (!cfg_trig_level[i])
                    ev = cfg_trig_inv[i] ? (!m_s2[i] && m_old[i]) : (m_s2[i] && !m_old[i]);
                else
                    ev = cfg_trig_inv[i] ? m_s2[i] : !m_s2[i];
                wipe = sts_clr_we && (int'(sts_clr_idx) == i / 32) && sts_clr_data[i % 32];
                if (!(cfg_gpio_use[i] && cfg_dir_in[i])) nxt[i] = 1'b0;
                else if (ev)                            nxt[i] = 1'b1;
                else if (wipe)                          nxt[i] = 1'b0;
                else                                    nxt[i] = m_sts[i];
                if (ena_we && (int'(ena_idx) == i / 32)) m_ena[i] = ena_data[i % 32];
            end
            m_sts = nxt;
            m_old = m_s2;
            m_s2  = m_s1;
            m_s1  = pin_level;
        end
    end

    // Per-clock comparison with the reference (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sts_words !== {1'b0, m_sts} || irq_out !== (|(m_sts & m_ena))) begin
                errors++;
                $display("FAIL model R2 R6 R8 R9 R10: actual sts=%h irq=%b expected sts=%h irq=%b",
                         sts_words, irq_out, {1'b0, m_sts}, |(m_sts & m_ena));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_word(input logic [1:0] idx, input logic [31:0] data);
        sts_clr_we = 1'b1; sts_clr_idx = idx; sts_clr_data = data;
        tick(1);
        sts_clr_we = 1'b0; sts_clr_data = '0;
    endtask

    task automatic ena_word(input logic [1:0] idx, input logic [31:0] data);
        ena_we = 1'b1; ena_idx = idx; ena_data = data;
        tick(1);
        ena_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        chk("R1 status after reset", 32'(|sts_words), 32'd0);
        chk("R1 irq after reset", 32'(irq_out), 32'd0);

        // R2 rising edge, with synchronizer latency
        pin_level[5] = 1'b1;
        tick(2);
        chk("R2 not yet visible after two edges", 32'(sts_words[5]), 32'd0);
        tick(1);
        chk("R2 rising edge latched", 32'(sts_words[5]), 32'd1);
        chk("R8 latched while disabled, line low", 32'(irq_out), 32'd0);
        ena_word(2'd0, 32'h0000_0020);
        chk("R8 enabled pending drives line", 32'(irq_out), 32'd1);

        // R6 write-one-to-clear
        clr_word(2'd0, ~32'h0000_0020);
        chk("R6 zero data bit keeps status", 32'(sts_words[5]), 32'd1);
        clr_word(2'd3, 32'hFFFF_FFFF);
        chk("R6 index 3 ignored", 32'(sts_words[5]), 32'd1);
        clr_word(2'd0, 32'h0000_0020);
        chk("R6 one clears", 32'(sts_words[5]), 32'd0);
        chk("R8 line drops after clear", 32'(irq_out), 32'd0);

        // R3 falling edge on pin 40
        cfg_trig_inv[40] = 1'b1;
        pin_level[40] = 1'b1;
        tick(4);
        chk("R3 rising ignored in falling mode", 32'(sts_words[40]), 32'd0);
        pin_level[40] = 1'b0;
        tick(3);
        chk("R3 falling edge latched", 32'(sts_words[40]), 32'd1);

        // R5 level high on pin 70
        cfg_trig_level[70] = 1'b1; cfg_trig_inv[70] = 1'b1;
        tick(3);
        chk("R5 low level does not set", 32'(sts_words[70]), 32'd0);
        pin_level[70] = 1'b1;
        tick(3);
        chk("R5 high level sets", 32'(sts_words[70]), 32'd1);
        clr_word(2'd2, 32'h0000_0040);
        chk("R5 clear while high does not stick", 32'(sts_words[70]), 32'd1);
        pin_level[70] = 1'b0;
        tick(3);
        clr_word(2'd2, 32'h0000_0040);
        chk("R5 clear after level gone", 32'(sts_words[70]), 32'd0);

        // R4 level low on pin 94 (pin already low)
        cfg_trig_level[94] = 1'b1; cfg_trig_inv[94] = 1'b0;
        tick(2);
        chk("R4 low level sets", 32'(sts_words[94]), 32'd1);
        chk("R10 pad bit reads zero", 32'(sts_words[95]), 32'd0);
        ena_word(2'd2, 32'h4000_0000);
        chk("R8 word 2 enable drives line", 32'(irq_out), 32'd1);
        clr_word(2'd2, 32'h4000_0000);
        chk("R4 clear while low does not stick", 32'(sts_words[94]), 32'd1);
        pin_level[94] = 1'b1;
        tick(3);
        clr_word(2'd2, 32'h4000_0000);
        chk("R4 clear after level gone", 32'(sts_words[94]), 32'd0);
        chk("R8 line low with nothing pending", 32'(irq_out), 32'd0);

        // R7 event and clear on the same edge (pin 10)
        pin_level[10] = 1'b1;
        tick(2);
        clr_word(2'd0, 32'h0000_0400);
        chk("R7 set wins over clear", 32'(sts_words[10]), 32'd1);
        clr_word(2'd0, 32'h0000_0400);
        chk("R6 later clear succeeds", 32'(sts_words[10]), 32'd0);

        // R9 disqualified pins
        cfg_gpio_use[20] = 1'b0;
        pin_level[20] = 1'b1;
        cfg_dir_in[21] = 1'b0;
        pin_level[21] = 1'b1;
        tick(3);
        chk("R9 non-gpio pin stays clear", 32'(sts_words[20]), 32'd0);
        chk("R9 output pin stays clear", 32'(sts_words[21]), 32'd0);
        pin_level[12] = 1'b1;
        tick(3);
        chk("R2 pin 12 latched", 32'(sts_words[12]), 32'd1);
        cfg_dir_in[12] = 1'b0;
        tick(1);
        chk("R9 disqualify wipes pending", 32'(sts_words[12]), 32'd0);
        cfg_dir_in[12] = 1'b1;
        tick(2);
        chk("R9 requalify without event stays clear", 32'(sts_words[12]), 32'd0);

        // R8 enable word replacement
        pin_level[33] = 1'b1;
        ena_word(2'd1, 32'h0000_0002);
        tick(3);
        chk("R8 word 1 pending drives line", 32'(irq_out), 32'd1);
        ena_word(2'd1, 32'h0000_0000);
        chk("R8 rewritten enable masks line", 32'(irq_out), 32'd0);
        chk("R8 status kept when masked", 32'(sts_words[33]), 32'd1);

        tick(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule